// File: doc/BRIEF.md
# Serial Command Decoder with Configuration Register Bank

This block is the control port of a small radio transmitter. A host drives a four-wire serial link made of a clock, a data input, an active-low select and a data output. Each command arrives MSB first. The block decodes it by its leading code bits and loads the addressed configuration word into a bank of nine 16-bit registers. Every register holds a defined power-on value. Frequency words that fall outside the legal channel window are refused, so the old setting stays.

One 8-bit code opens a data stream. Each bit clocked in after that code, until select rises, goes to the transmit FIFO as a single-bit write strobe, as long as the FIFO is enabled. A status word made of six sticky event flags is shifted out on the data output during every transfer. A complete all-zero command counts as a status read and clears those flags.

The serial pins are sampled in the system clock domain through a synchronizer. After reset the port ignores all traffic for a programmable number of cycles, which stands in for the internal reset pulse.

Top module: `txcmd_decoder`

## Requirements
- R1: Data is shifted in on a rising serial clock only while select is low. Serial clock edges while select is high shift nothing. A high select level clears the bit counter and the shift register.
- R2: After reset the register bank `reg_q` holds these values: index 0 configuration 9082h, 1 frequency AD57h, 2 power control C002h, 3 FIFO setup CE00h, 4 bit rate C813h, 5 clock/battery C213h, 6 wake period E196h, 7 wake extension C300h, 8 extended options B0CAh.
- R3: A command is decoded by prefix. The 4-bit prefixes are 1001 (index 0), 1010 (index 1) and 1110 (index 6). The 8-bit prefixes are C0h (2), CEh (3), C8h (4), C2h (5), C3h (7) and B0h (8). The whole 16-bit word, including its code bits, is stored.
- R4: A register changes only when select rises after exactly 16 bits. A transfer of any other length leaves every register unchanged.
- R5: A frequency command is stored only if its low 12 bits lie in 96..3903 inclusive. Otherwise the previous frequency word stays.
- R6: If the first 8 bits are C6h, each later bit before select rises gives one `fifo_wr` pulse with that bit on `fifo_din`. This happens only while bit 7 of register index 3 is 1. Such a transfer stores no register.
- R7: During every transfer, `spi_sdo` presents the flags MSB first in this order: FIFO low, FIFO empty, FIFO overflow, low battery, wake timeout, power-on. The first flag is valid before the first rising serial clock, and each later one follows a falling serial clock. The remaining bits are 0. `spi_sdo` is 0 while select is high.
- R8: The flags are sticky: an input pulse sets its flag, and reset sets the power-on flag. Only a complete 16-bit all-zero command clears them, when its select rises. They then reload from the current inputs.
- R9: For HOLD_CYC clock cycles after reset is released, serial traffic is ignored. Bits clocked in during that time are not counted.
- R10: A 16-bit word whose code matches none of the prefixes changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_sel_n | input | 1 | Active-low select |
| spi_sdo | output | 1 | Serial status data to host |
| flag_fifo_low | input | 1 | FIFO fill below threshold event |
| flag_fifo_empty | input | 1 | FIFO empty event |
| flag_fifo_ovf | input | 1 | FIFO overflow event |
| flag_low_batt | input | 1 | Supply below threshold event |
| flag_wake | input | 1 | Wake timer expiry event |
| reg_q | output | 9x16 | Register bank, index 8 in the top bits |
| fifo_wr | output | 1 | One-cycle FIFO bit write strobe |
| fifo_din | output | 1 | FIFO bit value |

## Verification
The bench builds the block with SYNC_STAGES = 2 and HOLD_CYC = 64, and drives a serial clock with a half period of ten system clocks. The 64-cycle hold is short enough for one transfer to start inside the hold window and end after it, so the dropped leading bits show up as a discarded command. The slow serial clock leaves room to sample `spi_sdo` well after each falling edge. It also leaves time to count every FIFO strobe of a 20-bit stream.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
  localparam int CMD_W    = 16;
  localparam int NUM_REGS = 9;
  localparam int STAT_W   = 6;
  localparam int IDX_W    = 4;

  localparam logic [IDX_W-1:0] IDX_CFG    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_FREQ   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_PWR    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_FIFO   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_RATE   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_CLKDIV = 4'd5;
  localparam logic [IDX_W-1:0] IDX_WAKE   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_XWAKE  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_XFEAT  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_NONE   = 4'd15;

  localparam logic [7:0]  STREAM_CODE = 8'hC6;
  localparam int          FE_BIT      = 7;
  localparam logic [11:0] FREQ_MIN    = 12'd96;
  localparam logic [11:0] FREQ_MAX    = 12'd3903;

  // Power-on value of each register slot
  function automatic logic [CMD_W-1:0] default_word(input int unsigned idx);
    logic [CMD_W-1:0] w;
    case (idx)
      0:       w = 16'h9082;
      1:       w = 16'hAD57;
      2:       w = 16'hC002;
      3:       w = 16'hCE00;
      4:       w = 16'hC813;
      5:       w = 16'hC213;
      6:       w = 16'hE196;
      7:       w = 16'hC300;
      8:       w = 16'hB0CA;
      default: w = '0;
    endcase
    return w;
  endfunction

  // Map a received word to its register slot by prefix
  function automatic logic [IDX_W-1:0] decode_word(input logic [CMD_W-1:0] w);
    logic [IDX_W-1:0] r;
    case (w[15:12])
      4'h9:    r = IDX_CFG;
      4'hA:    r = IDX_FREQ;
      4'hE:    r = IDX_WAKE;
      default: begin
        case (w[15:8])
          8'hC0:   r = IDX_PWR;
          8'hCE:   r = IDX_FIFO;
          8'hC8:   r = IDX_RATE;
          8'hC2:   r = IDX_CLKDIV;
          8'hC3:   r = IDX_XWAKE;
          8'hB0:   r = IDX_XFEAT;
          default: r = IDX_NONE;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic logic freq_ok(input logic [11:0] f);
    return (f >= FREQ_MIN) && (f <= FREQ_MAX);
  endfunction
endpackage

// File: rtl/txcmd_sync.sv
module txcmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic sel_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s,
  output logic sel_act,
  output logic sel_begin,
  output logic sel_end
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] sdi_p;
  logic [STAGES-1:0] seln_p;
  logic              sck_d;
  logic              act_d;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) begin
        sck_p  <= '0;
        sdi_p  <= '0;
        seln_p <= '1;
      end else begin
        sck_p  <= sck_i;
        sdi_p  <= sdi_i;
        seln_p <= sel_n_i;
      end
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) begin
        sck_p  <= '0;
        sdi_p  <= '0;
        seln_p <= '1;
      end else begin
        sck_p  <= {sck_p[STAGES-2:0], sck_i};
        sdi_p  <= {sdi_p[STAGES-2:0], sdi_i};
        seln_p <= {seln_p[STAGES-2:0], sel_n_i};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      act_d <= 1'b0;
    end else begin
      sck_d <= sck_p[TOP];
      act_d <= ~seln_p[TOP];
    end
  end

  assign sck_rise  = sck_p[TOP] & ~sck_d;
  assign sck_fall  = ~sck_p[TOP] & sck_d;
  assign sdi_s     = sdi_p[TOP];
  assign sel_act   = ~seln_p[TOP];
  assign sel_begin = sel_act & ~act_d;
  assign sel_end   = ~sel_act & act_d;
endmodule

// File: rtl/txcmd_shift.sv
module txcmd_shift
  import txcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_en,
  input  logic             sck_rise,
  input  logic             sdi_s,
  input  logic             sel_end,
  input  logic             fifo_en,
  output logic             word_vld,
  output logic [CMD_W-1:0] word_q,
  output logic             fifo_wr,
  output logic             fifo_din
);
  localparam int CNT_MAX = CMD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CMD_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             stream;
  logic [7:0]       head;

  assign head = {sh[6:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      cnt      <= '0;
      stream   <= 1'b0;
      fifo_wr  <= 1'b0;
      fifo_din <= 1'b0;
      word_vld <= 1'b0;
      word_q   <= '0;
    end else begin
      fifo_wr  <= 1'b0;
      word_vld <= 1'b0;
      if (sel_end) begin
        word_vld <= (cnt == CNT_W'(CMD_W)) && !stream;
        word_q   <= sh;
      end
      if (!frame_en) begin
        sh     <= '0;
        cnt    <= '0;
        stream <= 1'b0;
      end else if (sck_rise) begin
        sh <= {sh[CMD_W-2:0], sdi_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        if (stream) begin
          fifo_wr  <= fifo_en;
          fifo_din <= sdi_s;
        end else if ((cnt == CNT_W'(7)) && (head == STREAM_CODE)) begin
          stream <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/txcmd_status.sv
module txcmd_status
  import txcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-2:0] ev_i,
  input  logic              sel_act,
  input  logic              sel_begin,
  input  logic              sck_fall,
  input  logic              rd_clr,
  output logic              sdo
);
  logic [STAT_W-1:0] flags;
  logic [CMD_W-1:0]  out_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= STAT_W'(1);
    end else if (rd_clr) begin
      flags <= {ev_i, 1'b0};
    end else begin
      flags <= flags | {ev_i, 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sh <= '0;
      sdo    <= 1'b0;
    end else if (!sel_act) begin
      out_sh <= '0;
      sdo    <= 1'b0;
    end else if (sel_begin) begin
      out_sh <= {flags, (CMD_W-STAT_W)'(0)};
      sdo    <= flags[STAT_W-1];
    end else if (sck_fall) begin
      out_sh <= {out_sh[CMD_W-2:0], 1'b0};
      sdo    <= out_sh[CMD_W-2];
    end
  end
endmodule

// File: rtl/txcmd_regs.sv
module txcmd_regs
  import txcmd_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_vld,
  input  logic [CMD_W-1:0]                 wr_word,
  output logic [NUM_REGS-1:0][CMD_W-1:0]   reg_q
);
  logic [IDX_W-1:0] wr_idx;
  logic             accept;

  assign wr_idx = decode_word(wr_word);
  assign accept = wr_vld && ((wr_idx != IDX_FREQ) || freq_ok(wr_word[11:0]));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic [CMD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= default_word(g);
      end else if (accept && (wr_idx == IDX_W'(g))) begin
        q <= wr_word;
      end
    end
    assign reg_q[g] = q;
  end
endmodule

// File: rtl/txcmd_decoder.sv
module txcmd_decoder
  import txcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           spi_sck,
  input  logic                           spi_sdi,
  input  logic                           spi_sel_n,
  output logic                           spi_sdo,
  input  logic                           flag_fifo_low,
  input  logic                           flag_fifo_empty,
  input  logic                           flag_fifo_ovf,
  input  logic                           flag_low_batt,
  input  logic                           flag_wake,
  output logic [NUM_REGS-1:0][CMD_W-1:0] reg_q,
  output logic                           fifo_wr,
  output logic                           fifo_din
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic              sck_rise, sck_fall, sdi_s;
  logic              sel_act, sel_begin, sel_end;
  logic              frame_en, hold;
  logic [HOLD_W-1:0] hold_cnt;
  logic              word_vld;
  logic [CMD_W-1:0]  word_q;
  logic              rd_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= HOLD_W'(HOLD_CYC);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign hold     = (hold_cnt != '0);
  assign frame_en = sel_act & ~hold;
  assign rd_clr   = word_vld && (word_q == '0);

  txcmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sck_i     (spi_sck),
    .sdi_i     (spi_sdi),
    .sel_n_i   (spi_sel_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sdi_s     (sdi_s),
    .sel_act   (sel_act),
    .sel_begin (sel_begin),
    .sel_end   (sel_end)
  );

  txcmd_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .frame_en (frame_en),
    .sck_rise (sck_rise),
    .sdi_s    (sdi_s),
    .sel_end  (sel_end),
    .fifo_en  (reg_q[IDX_FIFO][FE_BIT]),
    .word_vld (word_vld),
    .word_q   (word_q),
    .fifo_wr  (fifo_wr),
    .fifo_din (fifo_din)
  );

  txcmd_status u_status (
    .clk       (clk),
    .rst       (rst),
    .ev_i      ({flag_fifo_low, flag_fifo_empty, flag_fifo_ovf, flag_low_batt, flag_wake}),
    .sel_act   (sel_act),
    .sel_begin (sel_begin),
    .sck_fall  (sck_fall),
    .rd_clr    (rd_clr),
    .sdo       (spi_sdo)
  );

  txcmd_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (word_vld),
    .wr_word (word_q),
    .reg_q   (reg_q)
  );
endmodule

// File: rtl/txcmd_checker.sv
module txcmd_checker
  import txcmd_pkg::*;
(
  input logic                           clk,
  input logic                           rst,
  input logic                           sel_act,
  input logic                           hold,
  input logic                           spi_sdo,
  input logic                           fifo_wr,
  input logic [NUM_REGS-1:0][CMD_W-1:0] reg_q
);
  AST_REG_STABLE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (sel_act && $past(sel_act)) |-> $stable(reg_q)); // R4

  AST_FREQ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (reg_q[IDX_FREQ][11:0] >= FREQ_MIN) && (reg_q[IDX_FREQ][11:0] <= FREQ_MAX)); // R5

  AST_FIFO_WR_GATED: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> reg_q[IDX_FIFO][FE_BIT]); // R6

  AST_FIFO_WR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(sel_act)); // R6

  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!sel_act && !$past(sel_act)) |-> !spi_sdo); // R7

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |-> (!fifo_wr && $stable(reg_q))); // R9

  AST_CODES_KEPT: assert property (@(posedge clk) disable iff (rst)
    (reg_q[IDX_CFG][15:12] == 4'h9) && (reg_q[IDX_PWR][15:8] == 8'hC0) &&
    (reg_q[IDX_XFEAT][15:8] == 8'hB0) && (reg_q[IDX_WAKE][15:12] == 4'hE)); // R3
endmodule

bind txcmd_decoder txcmd_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_act (sel_act),
  .hold    (hold),
  .spi_sdo (spi_sdo),
  .fifo_wr (fifo_wr),
  .reg_q   (reg_q)
);

// File: tb/test_txcmd_decoder.sv
`timescale 1ns/1ps
module test_txcmd_decoder;
  localparam int HALF = 10;
  localparam int HOLD = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, sdi = 1'b0, sel_n = 1'b1;
  logic f_low = 1'b0, f_empty = 1'b0, f_ovf = 1'b0, f_lbat = 1'b0, f_wake = 1'b0;
  logic sdo, fifo_wr, fifo_din;
  logic [8:0][15:0] regs;
  logic [15:0] model [9];
  int total = 0, fails = 0, fcnt = 0;
  logic [31:0] flog = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  txcmd_decoder #(.SYNC_STAGES(2), .HOLD_CYC(HOLD)) i_txcmd_decoder (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_sdi(sdi), .spi_sel_n(sel_n),
    .spi_sdo(sdo), .flag_fifo_low(f_low), .flag_fifo_empty(f_empty),
    .flag_fifo_ovf(f_ovf), .flag_low_batt(f_lbat), .flag_wake(f_wake),
    .reg_q(regs), .fifo_wr(fifo_wr), .fifo_din(fifo_din));

  always @(negedge clk) if (fifo_wr) begin
    flog = {flog[30:0], fifo_din};
    fcnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_defaults();
    model[0] = 16'h9082; model[1] = 16'hAD57; model[2] = 16'hC002;
    model[3] = 16'hCE00; model[4] = 16'hC813; model[5] = 16'hC213;
    model[6] = 16'hE196; model[7] = 16'hC300; model[8] = 16'hB0CA;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 9; i++) chk(req, {16'h0, regs[i]}, {16'h0, model[i]});
  endtask

  task automatic xfer(input logic [31:0] data, input int n, output logic [31:0] cap);
    cap = '0;
    sel_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      tick(HALF);
      cap[n-1-i] = sdo;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    sel_n = 1'b1;
    sdi = 1'b0;
    tick(2*HALF);
  endtask

  task automatic wr(input logic [15:0] w, input int idx);
    logic [31:0] cap;
    xfer({16'h0, w}, 16, cap);
    if (idx >= 0) model[idx] = w;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    model_defaults();
    tick(HOLD + 10);
  endtask

  task automatic t_reset();
    do_reset();
    check_regs("R2 reset value");
    chk("R7 sdo idle after reset", {31'h0, sdo}, 32'h0);
    chk("R6 no fifo strobe after reset", fcnt, 0);
  endtask

  task automatic t_status();
    logic [31:0] cap;
    f_low = 1'b1; f_lbat = 1'b1;
    tick(2);
    f_low = 1'b0; f_lbat = 1'b0;
    xfer(32'h0, 16, cap);
    chk("R7 status order on sdo", cap, 32'h9400);
    chk("R7 sdo low when deselected", {31'h0, sdo}, 32'h0);
    xfer(32'h0, 16, cap);
    chk("R8 flags cleared by read", cap, 32'h0);
    f_wake = 1'b1;
    tick(2);
    f_wake = 1'b0;
    xfer(32'hC002, 16, cap);
    chk("R8 flag streamed during write", cap, 32'h0800);
    xfer(32'h0, 16, cap);
    chk("R8 flag sticky across non-read", cap, 32'h0800);
    xfer(32'h0, 16, cap);
    chk("R8 cleared after second read", cap, 32'h0);
    check_regs("R8 status read stores nothing");
  endtask

  task automatic t_writes();
    wr(16'h9345, 0); wr(16'hA123, 1); wr(16'hC03B, 2);
    wr(16'hCE3F, 3); wr(16'hC8A7, 4); wr(16'hC2F1, 5);
    wr(16'hE123, 6); wr(16'hC3F5, 7); wr(16'hB01D, 8);
    check_regs("R3 prefix decode");
  endtask

  task automatic t_freq();
    wr(16'hA05F, -1);
    chk("R5 below window kept", {16'h0, regs[1]}, {16'h0, model[1]});
    wr(16'hAF40, -1);
    chk("R5 above window kept", {16'h0, regs[1]}, {16'h0, model[1]});
    wr(16'hA060, 1);
    chk("R5 lower edge 96 stored", {16'h0, regs[1]}, 32'hA060);
    wr(16'hAF3F, 1);
    chk("R5 upper edge 3903 stored", {16'h0, regs[1]}, 32'hAF3F);
    wr(16'hA000, -1);
    wr(16'hAFFF, -1);
    chk("R5 zero and max kept", {16'h0, regs[1]}, 32'hAF3F);
  endtask

  task automatic t_partial();
    logic [31:0] cap;
    xfer(32'h0000_60AA, 15, cap);
    check_regs("R4 15-bit command discarded");
    xfer(32'h00C0_AA55, 24, cap);
    check_regs("R4 24-bit command discarded");
    xfer(32'h0000_00C0, 8, cap);
    check_regs("R4 8-bit command discarded");
    sdi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    sdi = 1'b0;
    wr(16'hC015, 2);
    check_regs("R1 clocks while deselected ignored");
  endtask

  task automatic t_unknown();
    wr(16'h8123, -1);
    wr(16'hD0FF, -1);
    wr(16'h0001, -1);
    wr(16'hC6FF, -1);
    check_regs("R10 unmatched codes ignored");
  endtask

  task automatic t_fifo();
    logic [31:0] cap;
    int base;
    base = fcnt;
    xfer(32'h0000_C6A5, 16, cap);
    chk("R6 no strobe with fifo disabled", fcnt - base, 0);
    wr(16'hCE85, 3);
    base = fcnt;
    xfer(32'h000C_6A5C, 20, cap);
    chk("R6 strobe count 12-bit stream", fcnt - base, 12);
    chk("R6 streamed bits", flog & 32'hFFF, 32'hA5C);
    check_regs("R6 stream stores no register");
    base = fcnt;
    xfer(32'h0000_C6F0, 16, cap);
    chk("R6 strobe count 8-bit stream", fcnt - base, 8);
    chk("R6 streamed byte", flog & 32'hFF, 32'hF0);
    check_regs("R6 16-bit stream stores no register");
  endtask

  task automatic t_hold();
    logic [31:0] cap;
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    model_defaults();
    xfer(32'h0000_C0FF, 16, cap);
    chk("R9 command inside hold dropped", {16'h0, regs[2]}, 32'hC002);
    tick(HOLD);
    wr(16'hC0FF, 2);
    chk("R9 command after hold stored", {16'h0, regs[2]}, 32'hC0FF);
  endtask

  initial begin
    t_reset();
    t_status();
    t_writes();
    t_freq();
    t_partial();
    t_unknown();
    t_fifo();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule